// File: doc/BRIEF.md
# Scoreboard Dispatch, Issue and Writeback Controller

This block is the central control of an out-of-order core that has no register renaming. It serves five functional units: one integer ALU, one load unit, one store unit and two floating-point units. It tracks every instruction from the cycle it enters the window until it writes back. Each unit owns one window entry. An entry records the opcode, the destination name, the source names, and, for each source, the tag of the unit that still has to produce it. A second table holds, for each architectural register, the tag of the unit that will write that register next. Tag 0 means the value already sits in the register file. Tags 1 to 5 name ALU, load, store, FP unit 1 and FP unit 2 in that order.

Decoded instructions arrive in program order on a valid/ready handshake. `disp_ready` depends only on the offered class and destination, never on `disp_valid`. An instruction transfers on a cycle with both signals high. While ready is low the producer holds the instruction, and every younger instruction waits behind it. Each cycle the controller grants at most one issue, to the oldest instruction whose sources are ready. It drives the read addresses for the register file with that grant. When a unit signals completion, the controller later grants that unit's register-file write, as soon as no older reader still needs the old value. No values are bypassed. The datapath must make a register-file write in a cycle visible to a read in the same cycle.

Top module: `scoreboard_ctrl`

## Requirements
- R1: After reset no entry is busy, every register tag is 0, `issue_unit` and `wb_grant` are 0, and `disp_ready` is 1.
- R2: An accepted instruction takes a unit by class: `disp_cls` 0 takes the ALU (tag 1), 1 takes load (tag 2), 2 takes store (tag 3), and 3 takes FP unit 1 (tag 4) if that unit is free, otherwise FP unit 2 (tag 5). `disp_tag` reports the tag in the cycle of acceptance.
- R3: `disp_ready` is 0 when every unit that the offered class may use is occupied and none of them writes back in that cycle.
- R4: `disp_ready` is 0 when `disp_dst_en` is 1 and the destination register carries a nonzero tag that is not being cleared by a writeback in that cycle.
- R5: An entry does not issue while an enabled source still has a nonzero tag.
- R6: A writeback that clears the last pending tag of a waiting entry lets that entry issue in the same cycle. The read enable and address of each enabled source appear on `rd1_*` and `rd2_*`.
- R7: A writeback by a unit lets a new instruction for that unit, or one that writes that unit's destination register, be accepted in the same cycle.
- R8: At most one entry issues per cycle. Among the ready entries, the oldest by acceptance order wins, whatever its unit index.
- R9: A unit's writeback is held while any busy, not yet issued entry has an enabled source with tag 0 whose name equals that unit's destination.
- R10: A `fu_done` pulse for an issued unit leads to `wb_grant` for that unit no earlier than the following cycle, never in the pulse cycle. The writeback frees the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| disp_valid | input | 1 | decoded instruction offered |
| disp_ready | output | 1 | controller can accept the offered instruction |
| disp_cls | input | 2 | unit class: 0 ALU, 1 load, 2 store, 3 FP |
| disp_op | input | OP_W (4) | opcode carried to issue |
| disp_dst_en | input | 1 | instruction writes a register |
| disp_dst | input | REG_W (3) | destination register |
| disp_s1_en | input | 1 | first source used |
| disp_s1 | input | REG_W (3) | first source register |
| disp_s2_en | input | 1 | second source used |
| disp_s2 | input | REG_W (3) | second source register |
| disp_tag | output | 3 | tag of the unit taken by the offered instruction |
| fu_done | input | 5 | per-unit execution-complete pulse |
| issue_unit | output | 5 | one-hot issue grant |
| issue_op | output | OP_W (4) | opcode of the issuing entry |
| rd1_en | output | 1 | read first source this cycle |
| rd1_addr | output | REG_W (3) | first source address |
| rd2_en | output | 1 | read second source this cycle |
| rd2_addr | output | REG_W (3) | second source address |
| wb_grant | output | 5 | per-unit register-file write grant |

## Verification
The bench fills all five units and offers every class against a full window. A faulty structural check would accept an instruction and overwrite a live entry. It then lets a writeback and a new instruction for the same unit and register meet in one cycle. A design that frees before allocating would stall there, or would leave a stale busy bit. One sequence lets a load finish while an older, waiting FP instruction still reads the load's destination. A design without the write-after-read hold would grant that write too early. Another sequence makes a young ALU entry and an older FP entry ready in the same cycle. Picking by unit index instead of age would issue the ALU first. Dependent issue is checked in the very writeback cycle, so a one-cycle slip in tag clearing shows up.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int NFU   = 5;
  localparam int TAG_W = 3;

  typedef enum logic [1:0] {
    CLS_ALU = 2'd0,
    CLS_LD  = 2'd1,
    CLS_ST  = 2'd2,
    CLS_FP  = 2'd3
  } fu_cls_e;

  localparam int U_ALU = 0;
  localparam int U_LD  = 1;
  localparam int U_ST  = 2;
  localparam int U_FP1 = 3;
  localparam int U_FP2 = 4;

  // true when tag t names a unit whose bit in g is set
  function automatic logic tag_hit(logic [TAG_W-1:0] t, logic [NFU-1:0] g);
    logic h;
    h = 1'b0;
    for (int u = 0; u < NFU; u++)
      if (t == TAG_W'(u + 1)) h = g[u];
    return h;
  endfunction
endpackage

// File: rtl/sbc_regstat.sv
module sbc_regstat
  import sbc_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int REG_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFU-1:0]   wb_grant,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_reg,
  input  logic [TAG_W-1:0] set_tag,
  output logic [TAG_W-1:0] tag_eff [NREG]
);
  logic [TAG_W-1:0] tag_q [NREG];

  // tags seen this cycle, with writebacks of this cycle already cleared
  always_comb
    for (int r = 0; r < NREG; r++)
      tag_eff[r] = tag_hit(tag_q[r], wb_grant) ? '0 : tag_q[r];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) tag_q[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (tag_hit(tag_q[r], wb_grant)) tag_q[r] <= '0;
        if (set_en && set_reg == REG_W'(r)) tag_q[r] <= set_tag;
      end
    end
  end

  AST_WAW_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> tag_eff[set_reg] == '0); // R4
  AST_TAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> tag_q[$past(set_reg)] == $past(set_tag)); // R2
endmodule

// File: rtl/sbc_age_pick.sv
module sbc_age_pick #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc_oh,
  input  logic [N-1:0] keep,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  // older_q[i][j] set: entry i was accepted before entry j
  logic [N-1:0] older_q [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) older_q[i] <= '0;
    end else begin
      for (int k = 0; k < N; k++) begin
        if (alloc_oh[k]) begin
          older_q[k] <= '0;
          for (int j = 0; j < N; j++)
            if (j != k) older_q[j][k] <= keep[j];
        end
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_pick
    logic [N-1:0] beaten;
    always_comb
      for (int j = 0; j < N; j++) beaten[j] = req[j] & older_q[j][i];
    assign gnt[i] = req[i] & ~(|beaten);
  end

  AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R8
  AST_PICK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt)); // R8
endmodule

// File: rtl/sbc_war_chk.sv
module sbc_war_chk #(
  parameter int N     = 5,
  parameter int REG_W = 3
) (
  input  logic [N-1:0]     wr_en,
  input  logic [REG_W-1:0] wr_reg [N],
  input  logic [N-1:0]     ra_en,
  input  logic [REG_W-1:0] ra [N],
  input  logic [N-1:0]     rb_en,
  input  logic [REG_W-1:0] rb [N],
  output logic [N-1:0]     war
);
  for (genvar u = 0; u < N; u++) begin : g_wr
    logic [N-1:0] hit;
    always_comb
      for (int e = 0; e < N; e++)
        hit[e] = (e != u) &&
                 ((ra_en[e] && ra[e] == wr_reg[u]) ||
                  (rb_en[e] && rb[e] == wr_reg[u]));
    assign war[u] = wr_en[u] & (|hit);
  end
endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl
  import sbc_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int OP_W  = 4,
  parameter int REG_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  output logic             disp_ready,
  input  logic [1:0]       disp_cls,
  input  logic [OP_W-1:0]  disp_op,
  input  logic             disp_dst_en,
  input  logic [REG_W-1:0] disp_dst,
  input  logic             disp_s1_en,
  input  logic [REG_W-1:0] disp_s1,
  input  logic             disp_s2_en,
  input  logic [REG_W-1:0] disp_s2,
  output logic [TAG_W-1:0] disp_tag,
  input  logic [NFU-1:0]   fu_done,
  output logic [NFU-1:0]   issue_unit,
  output logic [OP_W-1:0]  issue_op,
  output logic             rd1_en,
  output logic [REG_W-1:0] rd1_addr,
  output logic             rd2_en,
  output logic [REG_W-1:0] rd2_addr,
  output logic [NFU-1:0]   wb_grant
);
  logic [NFU-1:0]   busy_q, iss_q, done_q, dsten_q, s1en_q, s2en_q;
  logic [OP_W-1:0]  op_q  [NFU];
  logic [REG_W-1:0] dst_q [NFU];
  logic [REG_W-1:0] s1_q  [NFU];
  logic [REG_W-1:0] s2_q  [NFU];
  logic [TAG_W-1:0] t1_q  [NFU];
  logic [TAG_W-1:0] t2_q  [NFU];

  logic [TAG_W-1:0] tag_eff [NREG];
  logic [NFU-1:0]   war, rdy, free_eff, want, alloc_oh, ra_en, rb_en;
  logic             fire, waw;

  // ---------------- writeback ----------------
  always_comb
    for (int u = 0; u < NFU; u++) begin
      ra_en[u] = busy_q[u] & ~iss_q[u] & s1en_q[u] & (t1_q[u] == '0);
      rb_en[u] = busy_q[u] & ~iss_q[u] & s2en_q[u] & (t2_q[u] == '0);
    end

  sbc_war_chk #(.N(NFU), .REG_W(REG_W)) war_i (
    .wr_en (busy_q & dsten_q),
    .wr_reg(dst_q),
    .ra_en (ra_en),
    .ra    (s1_q),
    .rb_en (rb_en),
    .rb    (s2_q),
    .war   (war)
  );

  assign wb_grant = busy_q & iss_q & done_q & ~war;

  // ---------------- dispatch ----------------
  assign free_eff = ~busy_q | wb_grant;

  always_comb begin
    want = '0;
    unique case (fu_cls_e'(disp_cls))
      CLS_ALU: want[U_ALU] = 1'b1;
      CLS_LD:  want[U_LD]  = 1'b1;
      CLS_ST:  want[U_ST]  = 1'b1;
      CLS_FP:  if (free_eff[U_FP1]) want[U_FP1] = 1'b1;
               else                 want[U_FP2] = 1'b1;
    endcase
  end

  always_comb begin
    disp_tag = '0;
    for (int u = 0; u < NFU; u++)
      if (want[u]) disp_tag = TAG_W'(u + 1);
  end

  assign waw        = disp_dst_en && (tag_eff[disp_dst] != '0);
  assign disp_ready = (|(want & free_eff)) && !waw;
  assign fire       = disp_valid && disp_ready;
  assign alloc_oh   = fire ? want : '0;

  sbc_regstat #(.NREG(NREG), .REG_W(REG_W)) regstat_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wb_grant(wb_grant),
    .set_en  (fire && disp_dst_en),
    .set_reg (disp_dst),
    .set_tag (disp_tag),
    .tag_eff (tag_eff)
  );

  // ---------------- issue ----------------
  always_comb
    for (int u = 0; u < NFU; u++)
      rdy[u] = busy_q[u] & ~iss_q[u] &
               ((t1_q[u] == '0) | tag_hit(t1_q[u], wb_grant)) &
               ((t2_q[u] == '0) | tag_hit(t2_q[u], wb_grant));

  sbc_age_pick #(.N(NFU)) pick_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .alloc_oh(alloc_oh),
    .keep    (busy_q & ~wb_grant),
    .req     (rdy),
    .gnt     (issue_unit)
  );

  always_comb begin
    issue_op = '0; rd1_en = 1'b0; rd1_addr = '0; rd2_en = 1'b0; rd2_addr = '0;
    for (int u = 0; u < NFU; u++)
      if (issue_unit[u]) begin
        issue_op = op_q[u];
        rd1_en   = s1en_q[u]; rd1_addr = s1_q[u];
        rd2_en   = s2en_q[u]; rd2_addr = s2_q[u];
      end
  end

  // ---------------- unit status table ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0; iss_q <= '0; done_q <= '0;
      dsten_q <= '0; s1en_q <= '0; s2en_q <= '0;
      for (int u = 0; u < NFU; u++) begin
        op_q[u] <= '0; dst_q[u] <= '0; s1_q[u] <= '0; s2_q[u] <= '0;
        t1_q[u] <= '0; t2_q[u] <= '0;
      end
    end else begin
      for (int u = 0; u < NFU; u++) begin
        if (alloc_oh[u]) begin
          busy_q[u]  <= 1'b1;
          iss_q[u]   <= 1'b0;
          done_q[u]  <= 1'b0;
          op_q[u]    <= disp_op;
          dsten_q[u] <= disp_dst_en;
          dst_q[u]   <= disp_dst;
          s1en_q[u]  <= disp_s1_en;
          s1_q[u]    <= disp_s1;
          s2en_q[u]  <= disp_s2_en;
          s2_q[u]    <= disp_s2;
          t1_q[u]    <= disp_s1_en ? tag_eff[disp_s1] : '0;
          t2_q[u]    <= disp_s2_en ? tag_eff[disp_s2] : '0;
        end else begin
          if (wb_grant[u]) begin
            busy_q[u] <= 1'b0; iss_q[u] <= 1'b0; done_q[u] <= 1'b0;
          end
          if (issue_unit[u]) iss_q[u] <= 1'b1;
          if (fu_done[u] && busy_q[u] && iss_q[u]) done_q[u] <= 1'b1;
          if (tag_hit(t1_q[u], wb_grant)) t1_q[u] <= '0;
          if (tag_hit(t2_q[u], wb_grant)) t2_q[u] <= '0;
        end
      end
    end
  end

  for (genvar u = 0; u < NFU; u++) begin : g_chk
    AST_WB_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_grant[u] && !alloc_oh[u]) |=> !busy_q[u]); // R10
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_oh[u] |-> (!busy_q[u] || wb_grant[u])); // R3
    AST_ISSUE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      issue_unit[u] |=> (iss_q[u] || !busy_q[u])); // R5
  end
endmodule

// File: tb/scoreboard_ctrl_tb_top.sv
module scoreboard_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       disp_valid, disp_ready;
  logic [1:0] disp_cls;
  logic [3:0] disp_op;
  logic       disp_dst_en, disp_s1_en, disp_s2_en;
  logic [2:0] disp_dst, disp_s1, disp_s2, disp_tag;
  logic [4:0] fu_done, issue_unit, wb_grant;
  logic [3:0] issue_op;
  logic       rd1_en, rd2_en;
  logic [2:0] rd1_addr, rd2_addr;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  scoreboard_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_cls(disp_cls), .disp_op(disp_op),
    .disp_dst_en(disp_dst_en), .disp_dst(disp_dst),
    .disp_s1_en(disp_s1_en), .disp_s1(disp_s1),
    .disp_s2_en(disp_s2_en), .disp_s2(disp_s2),
    .disp_tag(disp_tag), .fu_done(fu_done),
    .issue_unit(issue_unit), .issue_op(issue_op),
    .rd1_en(rd1_en), .rd1_addr(rd1_addr),
    .rd2_en(rd2_en), .rd2_addr(rd2_addr),
    .wb_grant(wb_grant)
  );

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  // next cycle: inputs change after the falling edge
  task automatic nxt();
    @(negedge clk);
    disp_valid = 1'b0; disp_dst_en = 1'b0; disp_s1_en = 1'b0; disp_s2_en = 1'b0;
    fu_done = '0;
  endtask

  task automatic offer(input int cls, input bit de, input int d,
                       input bit e1, input int a1, input bit e2, input int a2);
    disp_valid = 1'b1; disp_cls = 2'(cls); disp_op = 4'(cls + 8);
    disp_dst_en = de; disp_dst = 3'(d);
    disp_s1_en = e1; disp_s1 = 3'(a1);
    disp_s2_en = e2; disp_s2 = 3'(a2);
  endtask

  task automatic settle();
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; disp_valid = 1'b0; disp_cls = '0; disp_op = '0;
    disp_dst_en = 1'b0; disp_dst = '0; disp_s1_en = 1'b0; disp_s1 = '0;
    disp_s2_en = 1'b0; disp_s2 = '0; fu_done = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // ---- R1 reset state
    nxt(); settle();
    chk("R1 ready", disp_ready, 1);
    chk("R1 issue", issue_unit, 0);
    chk("R1 wb", wb_grant, 0);

    // ---- fill all units, one per cycle; each issues the next cycle
    for (int k = 0; k < 5; k++) begin
      nxt();
      offer((k < 4) ? k : 3, (k != 2), k + 1, 0, 0, 0, 0);
      settle();
      chk("R2 ready on free unit", disp_ready, 1);
      chk("R2 tag by class", disp_tag, k + 1);
      chk("R8 issue in accept order", issue_unit, (k == 0) ? 0 : (1 << (k - 1)));
    end
    // ---- R3 every class offered against a full window
    for (int c = 0; c < 4; c++) begin
      nxt(); offer(c, 0, 0, 0, 0, 0, 0); settle();
      chk("R3 full window stalls", disp_ready, 0);
      chk("R8 last issue", issue_unit, (c == 0) ? 5'b10000 : 0);
    end
    nxt(); fu_done = 5'b11111; settle();
    chk("R10 no wb in done cycle", wb_grant, 0);
    nxt(); offer(0, 1, 1, 0, 0, 0, 0); settle();
    chk("R10 wb all after done", wb_grant, 5'b11111);
    chk("R7 free and accept same cycle", disp_ready, 1);
    chk("R7 tag", disp_tag, 1);
    nxt(); settle();
    chk("R7 new entry issues", issue_unit, 5'b00001);
    nxt(); fu_done = 5'b00001; settle();
    nxt(); settle();
    chk("R10 single wb", wb_grant, 5'b00001);

    // ---- R5/R6/R4: load feeds FP
    nxt(); offer(1, 1, 2, 0, 0, 0, 0); settle();
    chk("R2 load tag", disp_tag, 2);
    nxt(); offer(3, 1, 5, 1, 2, 0, 0); settle();
    chk("R2 fp tag", disp_tag, 4);
    chk("R8 load issues", issue_unit, 5'b00010);
    nxt(); offer(0, 1, 2, 0, 0, 0, 0); fu_done = 5'b00010; settle();
    chk("R4 waw stall", disp_ready, 0);
    chk("R5 waits on tag", issue_unit, 0);
    nxt(); settle();
    chk("R6 wb", wb_grant, 5'b00010);
    chk("R6 dependent issue same cycle", issue_unit, 5'b01000);
    chk("R6 rd1_en", rd1_en, 1);
    chk("R6 rd1_addr", rd1_addr, 2);
    chk("R6 rd2_en", rd2_en, 0);
    chk("R6 issue_op", issue_op, 11);
    nxt(); fu_done = 5'b01000; settle();
    nxt(); settle();
    chk("R10 fp wb", wb_grant, 5'b01000);

    // ---- R9 write-after-read hold
    nxt(); offer(0, 1, 6, 0, 0, 0, 0); settle();
    nxt(); offer(3, 1, 7, 1, 6, 1, 3); settle();
    chk("R8 alu issues", issue_unit, 5'b00001);
    nxt(); offer(1, 1, 3, 0, 0, 0, 0); settle();
    chk("R9 load accepted", disp_ready, 1);
    chk("R5 fp waits", issue_unit, 0);
    nxt(); settle();
    chk("R9 load issues", issue_unit, 5'b00010);
    nxt(); fu_done = 5'b00010; settle();
    nxt(); fu_done = 5'b00001; settle();
    chk("R9 load wb held", wb_grant, 0);
    nxt(); settle();
    chk("R9 alu wb, load still held", wb_grant, 5'b00001);
    chk("R6 fp issues on alu wb", issue_unit, 5'b01000);
    chk("R6 rd2_addr", rd2_addr, 3);
    nxt(); fu_done = 5'b01000; settle();
    chk("R9 load wb after reader issued", wb_grant, 5'b00010);
    nxt(); settle();
    chk("R10 fp wb", wb_grant, 5'b01000);

    // ---- R8 age beats unit index
    nxt(); offer(1, 1, 4, 0, 0, 0, 0); settle();
    nxt(); offer(3, 0, 0, 1, 4, 0, 0); settle();
    chk("R2 fp1 reused", disp_tag, 4);
    nxt(); offer(0, 0, 0, 1, 4, 0, 0); fu_done = 5'b00010; settle();
    chk("R5 both wait", issue_unit, 0);
    nxt(); settle();
    chk("R8 older fp wins", issue_unit, 5'b01000);
    nxt(); fu_done = 5'b01000; settle();
    chk("R8 younger alu next", issue_unit, 5'b00001);
    nxt(); fu_done = 5'b00001; settle();
    chk("R10 fp wb", wb_grant, 5'b01000);
    nxt(); settle();
    chk("R10 alu wb", wb_grant, 5'b00001);

    nxt();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule